// File: doc/BRIEF.md
# Streaming Nearest-Neighbour Image Upscaler

This block takes a raster image delivered one pixel at a time and produces a resampled raster, normally larger, by picking for each output position the nearest source pixel at or before it. A pixel is three 8-bit channels packed into a 24-bit word, with red in bits 23:16, green in bits 15:8 and blue in bits 7:0. Pixels pass through unchanged; the block only chooses which source pixel each output position repeats.

Software or a parent block programs the input and output sizes and one scale step per axis, then pulses `start` at the beginning of each frame. The block pulls one source row at a time into an internal line store, through a valid/ready input. It then emits one or more output rows from that store, through a valid/ready output. The scale step is the ratio of input size to output size, in unsigned fixed point with 4 integer and 14 fraction bits. A step of 0.375 is 18'h1800 and a step of 1.0 is 18'h4000, so an upscale uses a step below 1.0. Each size is programmed as the true size minus one.

Input back-pressure: the block raises `din_ready` only while it is filling a row. A pixel moves only on a rising edge where `din_valid` and `din_ready` are both high. The producer may drop `din_valid` at any time. Output back-pressure: while `dout_valid` is high and `dout_ready` is low, the block holds the pixel and waits. The consumer may drop `dout_ready` at any time.

Top module: `img_upscaler`

## Requirements
- R1: An output pixel is bit-for-bit equal to the source pixel that was chosen for it, in all 24 bits. Red is in bits 23:16, green in bits 15:8 and blue in bits 7:0.
- R2: Output column x repeats source column floor(x * x_scale / 2^14), where x_scale is unsigned fixed point with 4 integer and 14 fraction bits. If that value exceeds `in_w`, the source column is `in_w` instead.
- R3: Output row y repeats source row floor(y * y_scale / 2^14), limited to `in_h`, with y_scale in the same 4.14 format.
- R4: Each size input is the true size minus one. A frame therefore emits exactly (out_w+1)*(out_h+1) pixels, in row-major order.
- R5: An input pixel is consumed only on an edge where `din_valid` and `din_ready` are both high. Input pixels are taken in row-major order, and `in_w`+1 pixels make one source row.
- R6: While `dout_valid` is high and `dout_ready` is low, `dout_valid` stays high and `dout_data` does not change on the next cycle.
- R7: A one-cycle `start` pulse aborts any frame in progress and restarts all row and column counting. On the following cycle `din_ready` is high and `dout_valid` is low. The size and scale inputs are captured at the `start` pulse, so changing them later in the frame has no effect.
- R8: After the last output pixel of a frame is accepted, `din_ready` and `dout_valid` stay low until the next `start`.
- R9: A source row is fetched only once the vertical position reaches it. If the vertical position advances by more than one row, the rows in between are still consumed, in order. A frame consumes exactly (min(floor(out_h * y_scale / 2^14), in_h) + 1) * (in_w + 1) input pixels.
- R10: After reset, and before the first `start`, `din_ready` and `dout_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new frame and captures the controls |
| in_w | input | 12 | Input width minus one |
| in_h | input | 12 | Input height minus one |
| out_w | input | 12 | Output width minus one |
| out_h | input | 12 | Output height minus one |
| x_scale | input | 18 | Horizontal step, input/output ratio in 4.14 fixed point |
| y_scale | input | 18 | Vertical step, input/output ratio in 4.14 fixed point |
| din_valid | input | 1 | Producer offers a pixel |
| din_ready | output | 1 | Block will take the offered pixel |
| din_data | input | 24 | Input pixel (red 23:16, green 15:8, blue 7:0) |
| dout_valid | output | 1 | Output pixel present |
| dout_ready | input | 1 | Consumer takes the output pixel |
| dout_data | output | 24 | Output pixel |

## Verification
The bench targets the following corner cases:

- **Column and row limiting (R2, R3):** the output extends past the source edge. A design without the limit would read stale or unwritten line-store entries and return wrong colours at the right and bottom edges.
- **Downscale on the vertical axis (R9):** the row position jumps by two. A design that fetched only one row per step would repeat the wrong rows. It would also leave the input stream misaligned, which shows up as a wrong consumed-pixel count.
- **Controls changed after `start`, and `start` mid-frame (R7):** a design that did not capture the controls, or did not clear its counters, would produce garbage sizes or frame contents that mix old and new data.
- **Random stalls on both sides (R5, R6):** a design that let data slip under stalls would skip or duplicate pixels. Any such pixel is caught by the per-pixel comparison or by the stability check on held output.

// File: rtl/upsc_pkg.sv
package upsc_pkg;
  localparam int unsigned SC_INT  = 4;
  localparam int unsigned SC_FRAC = 14;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_ROWCHK,
    ST_EMIT,
    ST_DONE
  } upsc_state_e;
endpackage

// File: rtl/upsc_accum.sv
// Fixed-point position accumulator: clears, or adds one step per event.
// Only the integer part leaves the module.
module upsc_accum #(
  parameter int unsigned STEP_W = 18,
  parameter int unsigned FRAC_W = 14,
  parameter int unsigned ACC_W  = 30,
  localparam int unsigned INT_W = ACC_W - FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic [STEP_W-1:0] inc,
  output logic [INT_W-1:0]  pos_int
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (step) acc_q <= acc_q + ACC_W'(inc);
  end

  assign pos_int = acc_q[ACC_W-1:FRAC_W];

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (acc_q >= $past(acc_q)));
endmodule

// File: rtl/upsc_clamp.sv
// Limits an integer position to a programmed last index.
module upsc_clamp #(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned LIM_W = 12
) (
  input  logic [VAL_W-1:0] val,
  input  logic [LIM_W-1:0] lim,
  output logic [LIM_W-1:0] idx
);
  always_comb begin
    if (val > VAL_W'(lim)) idx = lim;
    else                   idx = val[LIM_W-1:0];
  end
endmodule

// File: rtl/upsc_linebuf.sv
// Single source-row store: one synchronous write port, one combinational read.
module upsc_linebuf #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ADDR_W = 12,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr[IDX_W-1:0]] <= wdata;
  end

  assign rdata = mem[raddr[IDX_W-1:0]];

  // R5
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr < ADDR_W'(DEPTH)));
  // R2
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (raddr < ADDR_W'(DEPTH)));
endmodule

// File: rtl/img_upscaler.sv
module img_upscaler
  import upsc_pkg::*;
#(
  parameter int unsigned CH_W       = 8,
  parameter int unsigned CH_N       = 3,
  parameter int unsigned RES_W      = 12,
  parameter int unsigned LINE_DEPTH = 256,
  localparam int unsigned PIX_W   = CH_W * CH_N,
  localparam int unsigned SCALE_W = SC_INT + SC_FRAC,
  localparam int unsigned ACC_W   = RES_W + SC_INT + SC_FRAC,
  localparam int unsigned INT_W   = ACC_W - SC_FRAC,
  localparam int unsigned CNT_W   = RES_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RES_W-1:0]   in_w,
  input  logic [RES_W-1:0]   in_h,
  input  logic [RES_W-1:0]   out_w,
  input  logic [RES_W-1:0]   out_h,
  input  logic [SCALE_W-1:0] x_scale,
  input  logic [SCALE_W-1:0] y_scale,
  input  logic               din_valid,
  output logic               din_ready,
  input  logic [PIX_W-1:0]   din_data,
  output logic               dout_valid,
  input  logic               dout_ready,
  output logic [PIX_W-1:0]   dout_data
);
  upsc_state_e        state_q;
  logic [RES_W-1:0]   in_w_q, in_h_q, out_w_q, out_h_q;
  logic [SCALE_W-1:0] scale_q [2];
  logic [RES_W-1:0]   wcol_q, ocol_q, orow_q;
  logic [CNT_W-1:0]   fetched_q;

  logic               in_fire, out_fire, row_end, frame_end;
  logic [1:0]         acc_clr, acc_step;
  logic [INT_W-1:0]   pos_int [2];
  logic [RES_W-1:0]   lim [2];
  logic [RES_W-1:0]   src_idx [2];

  assign din_ready  = (state_q == ST_FILL);
  assign dout_valid = (state_q == ST_EMIT);
  assign in_fire    = din_valid && din_ready;
  assign out_fire   = dout_valid && dout_ready;
  assign row_end    = (ocol_q == out_w_q);
  assign frame_end  = row_end && (orow_q == out_h_q);

  // axis 0: horizontal position, cleared per output row
  // axis 1: vertical position, cleared per frame
  assign acc_clr[0]  = start || (out_fire && row_end);
  assign acc_step[0] = out_fire;
  assign acc_clr[1]  = start;
  assign acc_step[1] = out_fire && row_end && !frame_end;
  assign lim[0]      = in_w_q;
  assign lim[1]      = in_h_q;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    upsc_accum #(
      .STEP_W (SCALE_W),
      .FRAC_W (SC_FRAC),
      .ACC_W  (ACC_W)
    ) i_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (acc_clr[g]),
      .step    (acc_step[g]),
      .inc     (scale_q[g]),
      .pos_int (pos_int[g])
    );

    upsc_clamp #(
      .VAL_W (INT_W),
      .LIM_W (RES_W)
    ) i_clamp (
      .val (pos_int[g]),
      .lim (lim[g]),
      .idx (src_idx[g])
    );
  end

  upsc_linebuf #(
    .DEPTH  (LINE_DEPTH),
    .DATA_W (PIX_W),
    .ADDR_W (RES_W)
  ) i_line (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (in_fire),
    .waddr (wcol_q),
    .wdata (din_data),
    .raddr (src_idx[0]),
    .rdata (dout_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      in_w_q     <= '0;
      in_h_q     <= '0;
      out_w_q    <= '0;
      out_h_q    <= '0;
      scale_q[0] <= '0;
      scale_q[1] <= '0;
      wcol_q     <= '0;
      ocol_q     <= '0;
      orow_q     <= '0;
      fetched_q  <= '0;
    end else if (start) begin
      state_q    <= ST_FILL;
      in_w_q     <= in_w;
      in_h_q     <= in_h;
      out_w_q    <= out_w;
      out_h_q    <= out_h;
      scale_q[0] <= x_scale;
      scale_q[1] <= y_scale;
      wcol_q     <= '0;
      ocol_q     <= '0;
      orow_q     <= '0;
      fetched_q  <= '0;
    end else begin
      case (state_q)
        ST_FILL: begin
          if (in_fire) begin
            if (wcol_q == in_w_q) begin
              wcol_q    <= '0;
              fetched_q <= fetched_q + CNT_W'(1);
              state_q   <= ST_ROWCHK;
            end else begin
              wcol_q <= wcol_q + RES_W'(1);
            end
          end
        end
        ST_ROWCHK: begin
          // rows fetched so far must pass the current source row
          if (fetched_q <= CNT_W'(src_idx[1])) state_q <= ST_FILL;
          else                                  state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (out_fire) begin
            if (row_end) begin
              ocol_q <= '0;
              if (frame_end) begin
                state_q <= ST_DONE;
              end else begin
                orow_q  <= orow_q + RES_W'(1);
                state_q <= ST_ROWCHK;
              end
            end else begin
              ocol_q <= ocol_q + RES_W'(1);
            end
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && !start) |=> (dout_valid && $stable(dout_data)));

  // R7
  start_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (din_ready && !dout_valid && wcol_q == '0));

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && frame_end && !start) |=> (!din_ready && !dout_valid));

  // R5
  wcol_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_ready |-> (wcol_q <= in_w_q));

  // R9
  row_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !start) |-> (fetched_q == CNT_W'(src_idx[1]) + CNT_W'(1)));

  // R4
  ocol_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (ocol_q <= out_w_q && orow_q <= out_h_q));
endmodule

// File: tb/test_img_upscaler.sv
`timescale 1ns/1ps
module test_img_upscaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] in_w = '0, in_h = '0, out_w = '0, out_h = '0;
  logic [17:0] x_scale = '0, y_scale = '0;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [23:0] din_data = '0;
  logic        dout_valid;
  logic        dout_ready = 1'b0;
  logic [23:0] dout_data;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  img_upscaler i_img_upscaler (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_w(in_w), .in_h(in_h), .out_w(out_w), .out_h(out_h),
    .x_scale(x_scale), .y_scale(y_scale),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_pix(int x, int y, int iw, int ih,
                                          logic [17:0] xs, logic [17:0] ys,
                                          logic [7:0] tag);
    longint c = (longint'(x) * longint'(xs)) >>> 14;
    longint r = (longint'(y) * longint'(ys)) >>> 14;
    if (c > iw) c = iw;
    if (r > ih) r = ih;
    return {8'(r), 8'(c), tag};
  endfunction

  task automatic pulse_start(int iw, int ih, int ow, int oh,
                             logic [17:0] xs, logic [17:0] ys);
    @(negedge clk);
    in_w = 12'(iw); in_h = 12'(ih); out_w = 12'(ow); out_h = 12'(oh);
    x_scale = xs; y_scale = ys;
    din_valid = 1'b0; dout_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // controls are scrambled after the pulse; the block must have captured them
    in_w = 12'hABC; in_h = 12'h123; out_w = 12'h7; out_h = 12'h2;
    x_scale = 18'h3FFFF; y_scale = 18'h00001;
  endtask

  task automatic run_frame(int iw, int ih, int ow, int oh,
                           logic [17:0] xs, logic [17:0] ys, logic [7:0] tag,
                           int in_gap, int out_gap, string name);
    int n_in = 0, ox = 0, oy = 0, exp_in;
    longint rlast;
    bit hold = 0;
    logic [23:0] held = '0;
    logic [23:0] e;
    pulse_start(iw, ih, ow, oh, xs, ys);
    // R7: one cycle after start the block asks for input and shows no output
    check(din_ready && !dout_valid, "R7", {name, " ready after start"},
          {din_ready, dout_valid}, 2'b10);
    for (int t = 0; t < 40000 && oy <= oh; t++) begin
      din_valid  = (in_gap == 0) || (t % in_gap != 0);
      din_data   = {8'(n_in / (iw + 1)), 8'(n_in % (iw + 1)), tag};
      dout_ready = (out_gap == 0) || (t % out_gap != 1);
      if (hold) begin
        // R6: held pixel must survive back-pressure
        check(dout_valid && dout_data == held, "R6", {name, " held pixel"},
              dout_data, held);
        hold = 0;
      end
      if (din_valid && din_ready) n_in++;
      if (dout_valid) begin
        if (dout_ready) begin
          e = exp_pix(ox, oy, iw, ih, xs, ys, tag);
          // R1 R2 R3: chosen source pixel, unchanged bits
          check(dout_data == e, "R1/R2/R3", {name, " pixel"}, dout_data, e);
          if (ox == ow) begin ox = 0; oy++; end
          else ox++;
        end else begin
          hold = 1;
          held = dout_data;
        end
      end
      @(negedge clk);
    end
    // R4: full frame delivered
    check(oy == oh + 1 && ox == 0, "R4", {name, " output rows"}, oy, oh + 1);
    rlast = (longint'(oh) * longint'(ys)) >>> 14;
    if (rlast > ih) rlast = ih;
    exp_in = int'((rlast + 1) * (iw + 1));
    // R8: nothing requested or offered after the frame ends
    din_valid = 1'b1; dout_ready = 1'b1;
    for (int k = 0; k < 12; k++) begin
      if (din_ready) n_in++;
      check(!din_ready && !dout_valid, "R8", {name, " quiet after frame"},
            {din_ready, dout_valid}, 0);
      @(negedge clk);
    end
    din_valid = 1'b0;
    // R9 R5: exact input pixels consumed
    check(n_in == exp_in, "R9", {name, " input pixels consumed"}, n_in, exp_in);
  endtask

  task automatic test_reset();
    @(negedge clk);
    din_valid = 1'b1; dout_ready = 1'b1;
    for (int k = 0; k < 6; k++) begin
      // R10
      check(!din_ready && !dout_valid, "R10", "idle after reset",
            {din_ready, dout_valid}, 0);
      @(negedge clk);
    end
    din_valid = 1'b0;
  endtask

  task automatic test_restart();
    int fed = 0;
    pulse_start(7, 5, 20, 13, 18'h1800, 18'h1800);
    for (int t = 0; t < 25; t++) begin
      din_valid  = 1'b1;
      din_data   = {8'hAA, 8'(fed), 8'hAA};
      dout_ready = (t % 2 == 0);
      if (din_ready) fed++;
      @(negedge clk);
    end
    // R7: start mid-frame, new frame must contain only fresh data
    run_frame(4, 3, 9, 7, 18'h2000, 18'h2000, 8'h5B, 0, 0, "restart");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    // R2 R3: upscale by 1/0.375
    run_frame(7, 5, 20, 13, 18'h1800, 18'h1800, 8'h11, 0, 0, "up0375");
    // R5 R6: identity scale with stalls on both sides
    run_frame(5, 4, 5, 4, 18'h4000, 18'h4000, 8'h22, 3, 4, "unity_stall");
    // R2 R3: different steps per axis
    run_frame(9, 6, 19, 9, 18'h2000, 18'h2AAB, 8'h33, 5, 3, "mixed");
    // R9: vertical downscale skips rows
    run_frame(11, 9, 7, 4, 18'h6000, 18'h8000, 8'h44, 4, 0, "down");
    // R2 R3: positions past the source edge are limited
    run_frame(3, 2, 6, 4, 18'h4000, 18'h4000, 8'h55, 0, 2, "clamp");
    test_restart();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule